// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block steps through a microprogram and turns each step into a wide vector of control strobes for a datapath. The control store has two levels. A micro-program counter addresses a narrow 17-bit microcode ROM. Each microword does one of two things. A sequencing microword names the next micro-address and may depend on a condition. A nano-pointer microword selects an entry in a 68-bit nanocode ROM, and that entry expands into 196 control lines. A control pattern that many microroutines need is held once in the nano level, and every microword that needs it points to it.

An instruction decoder outside the block starts a routine by raising `dispatch` with an entry address. The controlled datapath sends back one condition bit, `condIn`, which conditional micro-branches test. Both ROMs are constant tables computed in the RTL.

Top module: `nano_sequencer`

## Requirements
- R1: While reset is asserted the micro-PC is set to 0. Microword 0 is an unconditional jump to itself, so after reset and with no dispatch the control outputs stay all zero.
- R2: Microword format (17 bits). Bit 16 is the kind tag: 1 means a sequencing (jump) word and 0 means a nano-pointer word. In a jump word, bit 15 is the conditional flag, bits 9:0 are the target and bits 14:10 are zero. In a nano-pointer word, bits 8:0 are the nano address.
- R3: Nanoword N(p) for pointer p: bits 8:0 = p, bits 17:9 = ~p, bits 55:18 = 0, bits 62:56 = p[6:0], bits 65:63 = p[8:6], bits 67:66 = p[1:0]. Decoded controls: ctrl[55:0] = nanoword[55:0]. Exactly one bit of ctrl[183:56] is set, at 56 + nanoword[62:56]. Exactly one bit of ctrl[191:184] is set, at 184 + nanoword[65:63]. Exactly one bit of ctrl[195:192] is set, at 192 + nanoword[67:66].
- R4: When `dispatch` is high, the micro-PC loads `entryAddr` at the next clock edge. This takes priority over whatever the current microword would do.
- R5: During a nano-pointer microword, the outputs show the decoded nanoword in that same cycle. The micro-PC then advances by one.
- R6: An unconditional jump microword loads its target into the micro-PC.
- R7: A conditional jump microword loads its target when `condIn` is 1. When `condIn` is 0 it advances the micro-PC by one.
- R8: All control outputs are zero while a jump microword is current.
- R9: Microprogram contents:
  - Address 16: nano 5. Address 17: nano 9. Address 18: conditional jump to 24. Address 19: nano 33. Address 20: jump to 0.
  - Address 24: nano 300. Address 25: nano 511. Address 26: jump to 0.
  - Address 32: nano 7. Address 33: jump to 16.
  - Every other address holds an unconditional jump to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dispatch | input | 1 | Load the micro-PC from `entryAddr` at the next edge |
| entryAddr | input | 10 | Entry micro-address derived from the opcode |
| condIn | input | 1 | Condition tested by conditional micro-branches |
| ctrlOut | output | 196 | Decoded control-signal vector |

## Verification
The assertions assume that `dispatch`, `entryAddr` and `condIn` are stable around each rising edge. They also assume that reset is held from time zero through the first edge, so every `$past` term refers to a cycle after reset. The bench holds reset from the start and changes inputs only on falling edges. It drops `dispatch` in the cycle after it starts a routine, so each sequencing path is seen without interference. The one exception is the priority test, which raises `dispatch` on purpose in the middle of a routine.

// File: rtl/nano_sequencer_pkg.sv
package nano_sequencer_pkg;
  localparam int UPC_W  = 10;
  localparam int UWORD_W = 17;
  localparam int NPTR_W = 9;
  localparam int NANO_W = 68;
  localparam int CODEA_W = 7;
  localparam int CODEB_W = 3;
  localparam int CODEC_W = 2;
  localparam int DIRECT_W = NANO_W - CODEA_W - CODEB_W - CODEC_W;
  localparam int CTRL_W = DIRECT_W + (2**CODEA_W) + (2**CODEB_W) + (2**CODEC_W);

  typedef struct packed {
    logic              nanoEn;
    logic [NPTR_W-1:0] nanoPtr;
  } seqCmd_t;

  function automatic logic [UWORD_W-1:0] mkJump(input logic isCond, input logic [UPC_W-1:0] tgt);
    logic [UWORD_W-1:0] w;
    w = '0;
    w[16] = 1'b1;
    w[15] = isCond;
    w[UPC_W-1:0] = tgt;
    return w;
  endfunction

  function automatic logic [UWORD_W-1:0] mkNano(input logic [NPTR_W-1:0] ptr);
    logic [UWORD_W-1:0] w;
    w = '0;
    w[NPTR_W-1:0] = ptr;
    return w;
  endfunction

  function automatic logic [UWORD_W-1:0] ucodeRom(input logic [UPC_W-1:0] addr);
    case (addr)
      10'd16:  return mkNano(9'd5);
      10'd17:  return mkNano(9'd9);
      10'd18:  return mkJump(1'b1, 10'd24);
      10'd19:  return mkNano(9'd33);
      10'd24:  return mkNano(9'd300);
      10'd25:  return mkNano(9'd511);
      10'd32:  return mkNano(9'd7);
      10'd33:  return mkJump(1'b0, 10'd16);
      default: return mkJump(1'b0, 10'd0);
    endcase
  endfunction

  function automatic logic [NANO_W-1:0] nanoRom(input logic [NPTR_W-1:0] p);
    logic [NANO_W-1:0] w;
    w = '0;
    w[8:0]   = p;
    w[17:9]  = ~p;
    w[62:56] = p[6:0];
    w[65:63] = p[8:6];
    w[67:66] = p[1:0];
    return w;
  endfunction
endpackage

// File: rtl/nano_sequencer_ctrl.sv
module nano_sequencer_ctrl
  import nano_sequencer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dispatch,
  input  logic [UPC_W-1:0] entryAddr,
  input  logic             condIn,
  output seqCmd_t          cmd
);
  logic [UPC_W-1:0]   microPc;
  logic [UPC_W-1:0]   nextPc;
  logic [UWORD_W-1:0] uWord;
  logic               isJump;
  logic               condFlag;
  logic               takeJump;

  assign uWord    = ucodeRom(microPc);
  assign isJump   = uWord[16];
  assign condFlag = uWord[15];
  assign takeJump = isJump && (!condFlag || condIn);

  always_comb begin
    if (dispatch)      nextPc = entryAddr;
    else if (takeJump) nextPc = uWord[UPC_W-1:0];
    else               nextPc = microPc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) microPc <= '0;
    else     microPc <= nextPc;
  end

  assign cmd.nanoEn  = !isJump;
  assign cmd.nanoPtr = uWord[NPTR_W-1:0];

  // R1: first cycle after reset starts from micro-address 0
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> microPc == '0);
  // R2: jump words keep their reserved bits clear
  p_jump_format_r2: assert property (@(posedge clk) disable iff (rst)
    isJump |-> uWord[14:10] == '0);
  // R4: dispatch loads the entry address
  p_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
    dispatch |=> microPc == $past(entryAddr));
  // R5: nano-pointer words step by one
  p_nano_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && !isJump) |=> microPc == $past(microPc) + 1'b1);
  // R6: unconditional jump reaches its target
  p_uncond_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && isJump && !condFlag) |=> microPc == $past(uWord[UPC_W-1:0]));
  // R7: conditional jump not taken falls through
  p_cond_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && isJump && condFlag && !condIn) |=> microPc == $past(microPc) + 1'b1);
endmodule

// File: rtl/nano_sequencer_dp.sv
module nano_sequencer_dp
  import nano_sequencer_pkg::*;
(
  input  seqCmd_t           cmd,
  output logic [CTRL_W-1:0] ctrlOut
);
  localparam int A_N  = 2**CODEA_W;
  localparam int B_N  = 2**CODEB_W;
  localparam int C_N  = 2**CODEC_W;
  localparam int A_LO = DIRECT_W;
  localparam int B_LO = A_LO + A_N;
  localparam int C_LO = B_LO + B_N;
  localparam int NA_LO = DIRECT_W;
  localparam int NB_LO = NA_LO + CODEA_W;
  localparam int NC_LO = NB_LO + CODEB_W;

  logic [NANO_W-1:0] nanoWord;
  logic [CTRL_W-1:0] decoded;

  assign nanoWord = nanoRom(cmd.nanoPtr);

  always_comb begin
    decoded = '0;
    decoded[DIRECT_W-1:0] = nanoWord[DIRECT_W-1:0];
    decoded[A_LO +: A_N]  = A_N'(1) << nanoWord[NA_LO +: CODEA_W];
    decoded[B_LO +: B_N]  = B_N'(1) << nanoWord[NB_LO +: CODEB_W];
    decoded[C_LO +: C_N]  = C_N'(1) << nanoWord[NC_LO +: CODEC_W];
  end

  assign ctrlOut = cmd.nanoEn ? decoded : '0;
endmodule

// File: rtl/nano_sequencer.sv
module nano_sequencer
  import nano_sequencer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dispatch,
  input  logic [UPC_W-1:0]  entryAddr,
  input  logic              condIn,
  output logic [CTRL_W-1:0] ctrlOut
);
  seqCmd_t cmd;

  nano_sequencer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .dispatch(dispatch),
    .entryAddr(entryAddr), .condIn(condIn), .cmd(cmd)
  );

  nano_sequencer_dp u_dp (.cmd(cmd), .ctrlOut(ctrlOut));

  // R8: sequencing-only cycles drive no control line
  p_quiet_jump_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd.nanoEn |-> ctrlOut == '0);
  // R3: each decoded one-hot group has exactly one line set
  p_onehot_groups_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.nanoEn |-> ($countones(ctrlOut[183:56]) == 1 &&
                    $countones(ctrlOut[191:184]) == 1 &&
                    $countones(ctrlOut[195:192]) == 1));
endmodule

// File: tb/nano_sequencer_tb.sv
`timescale 1ns/1ps
module nano_sequencer_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dispatch = 1'b0;
  logic [9:0]   entryAddr = '0;
  logic         condIn = 1'b0;
  logic [195:0] ctrlOut;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nano_sequencer u_dut (
    .clk(clk), .rst(rst), .dispatch(dispatch),
    .entryAddr(entryAddr), .condIn(condIn), .ctrlOut(ctrlOut)
  );

  function automatic logic [195:0] expNano(input logic [8:0] p);
    logic [195:0] v;
    v = '0;
    v[8:0]  = p;
    v[17:9] = ~p;
    v[56 + int'(p[6:0])] = 1'b1;
    v[184 + int'(p[8:6])] = 1'b1;
    v[192 + int'(p[1:0])] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [195:0] exp);
    total++;
    if (ctrlOut !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, ctrlOut, exp);
    end
  endtask

  task automatic startAt(input logic [9:0] addr);
    @(negedge clk);
    dispatch = 1'b1;
    entryAddr = addr;
    @(negedge clk);
    dispatch = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", '0);
    repeat (3) @(negedge clk);
    check("R1 idle", '0);
  endtask

  task automatic testFallThrough();
    condIn = 1'b0;
    startAt(10'd16);
    check("R4 R5 nano5", expNano(9'd5));
    @(negedge clk); check("R5 nano9", expNano(9'd9));
    @(negedge clk); check("R8 cond jump quiet", '0);
    @(negedge clk); check("R7 not taken", expNano(9'd33));
    @(negedge clk); check("R8 jump quiet", '0);
    @(negedge clk); check("R6 back to idle", '0);
  endtask

  task automatic testTaken();
    startAt(10'd16);
    check("R4 nano5", expNano(9'd5));
    @(negedge clk); check("R5 nano9", expNano(9'd9));
    condIn = 1'b1;
    @(negedge clk); check("R8 quiet", '0);
    @(negedge clk); check("R7 taken", expNano(9'd300));
    condIn = 1'b0;
    @(negedge clk); check("R3 nano511", expNano(9'd511));
    @(negedge clk); check("R6 jump", '0);
    @(negedge clk); check("R1 idle", '0);
  endtask

  task automatic testPriority();
    startAt(10'd16);
    check("R4 nano5", expNano(9'd5));
    dispatch = 1'b1;
    entryAddr = 10'd32;
    @(negedge clk);
    dispatch = 1'b0;
    check("R4 priority", expNano(9'd7));
    @(negedge clk); check("R8 quiet", '0);
    @(negedge clk); check("R6 uncond target", expNano(9'd5));
  endtask

  task automatic testDefault();
    startAt(10'd700);
    check("R9 default word", '0);
    @(negedge clk); check("R9 default to idle", '0);
    startAt(10'd19);
    check("R3 nano33", expNano(9'd33));
  endtask

  initial begin
    testReset();
    testFallThrough();
    testTaken();
    testPriority();
    testDefault();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule